// File: doc/BRIEF.md
# Atomic Set/Clear/Toggle GPIO Port

This block is a memory-mapped general-purpose I/O port with `N` pins. Software never rewrites the output value register as a whole. It writes a mask to one of three write-one registers. A 1 in the mask sets, clears or inverts the matching output bit, and a 0 leaves that bit alone. Any group of pins can therefore change in one bus write, with no read-modify-write sequence.

Each pin has its own direction bit. The data register returns the synchronized pad levels, so software can poll input pins. The port has no interrupt output.

A contiguous upper group of pins can be handed to an alternate function. A strap input is captured while reset is asserted:

- **Strap high:** the group comes up as GPIO and stays locked there.
- **Strap low:** the group comes up in alternate-function mode, and software may later move it to GPIO.

Pins named in a parameter mask behave as open-drain outputs.

Top module: `gpio_atomic_port`

## Requirements
- R1: After reset the output value register is all zeros and every direction bit is 0 (input), so no GPIO-controlled pin has its pad output-enable asserted.
- R2: A write to address 1 (set) forces to 1 every output bit whose write-data bit is 1; all other output bits keep their value.
- R3: A write to address 2 (clear) forces to 0 every output bit whose write-data bit is 1; all other output bits keep their value.
- R4: A write to address 3 (toggle) inverts every output bit whose write-data bit is 1; all other output bits keep their value.
- R5: Address 4 holds one direction bit per pin (1 = output, 0 = input), readable and writable. On a GPIO-controlled push-pull pin, the pad output-enable equals the direction bit and the pad output equals the output value bit.
- R6: A read of address 0 returns the pad input levels as seen through a two-flop synchronizer: a level change becomes visible two clock edges later. Writes to address 0 change nothing.
- R7: On a GPIO-controlled pin selected by `OD_MASK`, the pad output is always 0 and the output-enable is high only when the pin is an output with value 0.
- R8: With the strap high at reset, address 5 (mode, bit 0: 1 = group is GPIO) reads 1, writes to it are ignored, and the group pins are GPIO-controlled.
- R9: With the strap low at reset, the mode bit reads 0 and the group pads follow the alternate-function output and enable inputs. Writing mode bit 0 switches the group between GPIO (1) and alternate function (0).
- R10: Reads of addresses 1 to 3 return the output value register. Addresses 6 and 7 read as 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; the strap is captured while it is low |
| strap_gpio_i | input | 1 | Reset strap: 1 locks the upper group as GPIO |
| bus_valid_i | input | 1 | Bus access valid this cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | N | Write data / mask |
| bus_rdata_o | output | N | Read data (combinational, valid during a read) |
| pad_in_i | input | N | Pad input levels |
| pad_out_o | output | N | Pad output values |
| pad_oe_o | output | N | Pad output enables |
| alt_out_i | input | GRP_W | Alternate-function output values for the group |
| alt_oe_i | input | GRP_W | Alternate-function output enables for the group |

## Verification
The assertions check on every cycle:

- the effect of each set, clear and toggle write on the output register, and that the register holds otherwise;
- that a locked group never leaves GPIO mode;
- the push-pull, open-drain and alternate-function enable rules at the pads;
- the two-cycle synchronizer latency of data reads.

Only the bench scenarios can show that reset values are right, that both strap settings yield the right start-up mode, that ignored writes truly leave state untouched, and that a long mixed sequence of masks ends in the arithmetically expected pin state.

// File: rtl/gpio_atomic_pkg.sv
package gpio_atomic_pkg;
    typedef enum logic [2:0] {
        REG_DATA = 3'd0,
        REG_SET  = 3'd1,
        REG_CLR  = 3'd2,
        REG_TOG  = 3'd3,
        REG_DIR  = 3'd4,
        REG_MODE = 3'd5
    } reg_addr_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] sync_o
);
    typedef struct packed {
        logic [N-1:0] stage1;
        logic [N-1:0] stage2;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d        = sync_q;
        sync_d.stage1 = async_i;
        sync_d.stage2 = sync_q.stage1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign sync_o = sync_q.stage2;
endmodule

// File: rtl/gpio_ctrl_regs.sv
module gpio_ctrl_regs
    import gpio_atomic_pkg::*;
#(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         strap_i,
    input  logic         wr_en_i,
    input  logic [2:0]   addr_i,
    input  logic [N-1:0] wdata_i,
    output logic [N-1:0] out_o,
    output logic [N-1:0] dir_o,
    output logic         gpio_mode_o,
    output logic         lock_o
);
    typedef struct packed {
        logic [N-1:0] out_val;
        logic [N-1:0] dir;
        logic         gpio_mode;
        logic         lock;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_en_i) begin
            case (reg_addr_e'(addr_i))
                REG_SET:  regs_d.out_val = regs_q.out_val | wdata_i;
                REG_CLR:  regs_d.out_val = regs_q.out_val & ~wdata_i;
                REG_TOG:  regs_d.out_val = regs_q.out_val ^ wdata_i;
                REG_DIR:  regs_d.dir     = wdata_i;
                REG_MODE: if (!regs_q.lock) regs_d.gpio_mode = wdata_i[0];
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.out_val   <= '0;
            regs_q.dir       <= '0;
            regs_q.gpio_mode <= strap_i;
            regs_q.lock      <= strap_i;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign out_o       = regs_q.out_val;
    assign dir_o       = regs_q.dir;
    assign gpio_mode_o = regs_q.gpio_mode;
    assign lock_o      = regs_q.lock;
endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux #(
    parameter int           N       = 16,
    parameter int           GRP_LO  = 10,
    parameter int           GRP_W   = 6,
    parameter logic [N-1:0] OD_MASK = '0
) (
    input  logic [N-1:0]     out_i,
    input  logic [N-1:0]     dir_i,
    input  logic             gpio_mode_i,
    input  logic [GRP_W-1:0] alt_out_i,
    input  logic [GRP_W-1:0] alt_oe_i,
    output logic [N-1:0]     pad_out_o,
    output logic [N-1:0]     pad_oe_o
);
    localparam int GRP_HI = GRP_LO + GRP_W - 1;

    logic [N-1:0] gp_out, gp_oe;

    for (genvar i = 0; i < N; i++) begin : g_pin
        if (OD_MASK[i]) begin : g_od
            assign gp_out[i] = 1'b0;
            assign gp_oe[i]  = dir_i[i] & ~out_i[i];
        end else begin : g_pp
            assign gp_out[i] = out_i[i];
            assign gp_oe[i]  = dir_i[i];
        end

        if (i >= GRP_LO && i <= GRP_HI) begin : g_grp
            assign pad_out_o[i] = gpio_mode_i ? gp_out[i] : alt_out_i[i-GRP_LO];
            assign pad_oe_o[i]  = gpio_mode_i ? gp_oe[i]  : alt_oe_i[i-GRP_LO];
        end else begin : g_plain
            assign pad_out_o[i] = gp_out[i];
            assign pad_oe_o[i]  = gp_oe[i];
        end
    end
endmodule

// File: rtl/gpio_atomic_port.sv
module gpio_atomic_port
    import gpio_atomic_pkg::*;
#(
    parameter int           N       = 16,
    parameter int           GRP_LO  = 10,
    parameter int           GRP_W   = 6,
    parameter logic [N-1:0] OD_MASK = 16'h0402
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strap_gpio_i,
    input  logic             bus_valid_i,
    input  logic             bus_we_i,
    input  logic [2:0]       bus_addr_i,
    input  logic [N-1:0]     bus_wdata_i,
    output logic [N-1:0]     bus_rdata_o,
    input  logic [N-1:0]     pad_in_i,
    output logic [N-1:0]     pad_out_o,
    output logic [N-1:0]     pad_oe_o,
    input  logic [GRP_W-1:0] alt_out_i,
    input  logic [GRP_W-1:0] alt_oe_i
);
    logic [N-1:0] out_val, dir_val, pin_sync;
    logic         gpio_mode, lock;
    logic         wr_en, rd_en;

    assign wr_en = bus_valid_i & bus_we_i;
    assign rd_en = bus_valid_i & ~bus_we_i;

    gpio_in_sync #(.N(N)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pad_in_i),
        .sync_o  (pin_sync)
    );

    gpio_ctrl_regs #(.N(N)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .strap_i     (strap_gpio_i),
        .wr_en_i     (wr_en),
        .addr_i      (bus_addr_i),
        .wdata_i     (bus_wdata_i),
        .out_o       (out_val),
        .dir_o       (dir_val),
        .gpio_mode_o (gpio_mode),
        .lock_o      (lock)
    );

    gpio_pad_mux #(.N(N), .GRP_LO(GRP_LO), .GRP_W(GRP_W), .OD_MASK(OD_MASK)) u_pads (
        .out_i       (out_val),
        .dir_i       (dir_val),
        .gpio_mode_i (gpio_mode),
        .alt_out_i   (alt_out_i),
        .alt_oe_i    (alt_oe_i),
        .pad_out_o   (pad_out_o),
        .pad_oe_o    (pad_oe_o)
    );

    always_comb begin
        bus_rdata_o = '0;
        if (rd_en) begin
            case (reg_addr_e'(bus_addr_i))
                REG_DATA: bus_rdata_o = pin_sync;
                REG_SET,
                REG_CLR,
                REG_TOG:  bus_rdata_o = out_val;
                REG_DIR:  bus_rdata_o = dir_val;
                REG_MODE: bus_rdata_o = N'(gpio_mode);
                default:  bus_rdata_o = '0;
            endcase
        end
    end
endmodule

// File: rtl/gpio_atomic_port_chk.sv
module gpio_atomic_port_chk #(
    parameter int           N       = 16,
    parameter int           GRP_LO  = 10,
    parameter int           GRP_W   = 6,
    parameter logic [N-1:0] OD_MASK = '0
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_valid_i,
    input logic             bus_we_i,
    input logic [2:0]       bus_addr_i,
    input logic [N-1:0]     bus_wdata_i,
    input logic [N-1:0]     bus_rdata_o,
    input logic [N-1:0]     pad_in_i,
    input logic [N-1:0]     pad_out_o,
    input logic [N-1:0]     pad_oe_o,
    input logic [GRP_W-1:0] alt_oe_i,
    input logic [N-1:0]     out_val,
    input logic [N-1:0]     dir_val,
    input logic             gpio_mode,
    input logic             lock
);
    localparam logic [N-1:0] GRP_MASK = N'(((2 ** GRP_W) - 1) << GRP_LO);

    logic [N-1:0] gp_pins;
    logic [1:0]   since_rst;
    logic         wr_out;

    assign gp_pins = gpio_mode ? '1 : ~GRP_MASK;
    assign wr_out  = bus_valid_i && bus_we_i && (bus_addr_i inside {3'd1, 3'd2, 3'd3});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    AST_SET_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid_i && bus_we_i && bus_addr_i == 3'd1) |=> ((out_val & $past(bus_wdata_i)) == $past(bus_wdata_i))); // R2
    AST_CLR_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid_i && bus_we_i && bus_addr_i == 3'd2) |=> ((out_val & $past(bus_wdata_i)) == '0)); // R3
    AST_TOG_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid_i && bus_we_i && bus_addr_i == 3'd3) |=> (out_val == ($past(out_val) ^ $past(bus_wdata_i)))); // R4
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_out |=> $stable(out_val)); // R10
    AST_PP_OE: assert property (@(posedge clk) disable iff (!rst_n)
        (((pad_oe_o ^ dir_val) | (pad_out_o ^ out_val)) & gp_pins & ~OD_MASK) == '0); // R5
    AST_OD_PINS: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_out_o | (pad_oe_o & out_val) | (pad_oe_o & ~dir_val)) & gp_pins & OD_MASK) == '0); // R7
    AST_LOCKED_GPIO: assert property (@(posedge clk) disable iff (!rst_n)
        lock |-> gpio_mode); // R8
    AST_ALT_OE: assert property (@(posedge clk) disable iff (!rst_n)
        !gpio_mode |-> (pad_oe_o[GRP_LO +: GRP_W] == alt_oe_i)); // R9
    AST_SYNC_LAT: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3 && bus_valid_i && !bus_we_i && bus_addr_i == 3'd0)
            |-> (bus_rdata_o == $past(pad_in_i, 2))); // R6
endmodule

bind gpio_atomic_port gpio_atomic_port_chk #(
    .N(N), .GRP_LO(GRP_LO), .GRP_W(GRP_W), .OD_MASK(OD_MASK)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_valid_i (bus_valid_i),
    .bus_we_i    (bus_we_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_rdata_o),
    .pad_in_i    (pad_in_i),
    .pad_out_o   (pad_out_o),
    .pad_oe_o    (pad_oe_o),
    .alt_oe_i    (alt_oe_i),
    .out_val     (out_val),
    .dir_val     (dir_val),
    .gpio_mode   (gpio_mode),
    .lock        (lock)
);

// File: tb/tb_gpio_atomic_port.sv
`timescale 1ns/1ps
module tb_gpio_atomic_port;
    localparam int          N       = 8;
    localparam int          GRP_LO  = 4;
    localparam int          GRP_W   = 3;
    localparam logic [N-1:0] OD_MASK = 8'b1000_0010;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic strap = 1'b1;
    logic bus_valid = 1'b0, bus_we = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [N-1:0] bus_wdata = '0, bus_rdata;
    logic [N-1:0] pad_in, pad_out, pad_oe, ext_lvl = '0;
    logic [GRP_W-1:0] alt_out = '0, alt_oe = '0;

    logic [N-1:0] m_out, m_dir, e_pout, e_poe;
    logic m_gpio;
    int errors = 0, checks = 0;

    always #2.5 clk = ~clk;

    gpio_atomic_port #(.N(N), .GRP_LO(GRP_LO), .GRP_W(GRP_W), .OD_MASK(OD_MASK)) dut (
        .clk(clk), .rst_n(rst_n), .strap_gpio_i(strap),
        .bus_valid_i(bus_valid), .bus_we_i(bus_we), .bus_addr_i(bus_addr),
        .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
        .pad_in_i(pad_in), .pad_out_o(pad_out), .pad_oe_o(pad_oe),
        .alt_out_i(alt_out), .alt_oe_i(alt_oe)
    );

    always_comb begin
        for (int i = 0; i < N; i++) pad_in[i] = pad_oe[i] ? pad_out[i] : ext_lvl[i];
    end

    always_comb begin
        for (int i = 0; i < N; i++) begin
            if (i >= GRP_LO && i < GRP_LO + GRP_W && !m_gpio) begin
                e_pout[i] = alt_out[i-GRP_LO];
                e_poe[i]  = alt_oe[i-GRP_LO];
            end else if (OD_MASK[i]) begin
                e_pout[i] = 1'b0;
                e_poe[i]  = m_dir[i] & ~m_out[i];
            end else begin
                e_pout[i] = m_out[i];
                e_poe[i]  = m_dir[i];
            end
        end
    end

    task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [N-1:0] d);
        bus_valid = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_valid = 1'b0;
    endtask

    task automatic check_pads(input string req);
        #0.5;
        check({req, " pad_out"}, pad_out, e_pout);
        check({req, " pad_oe"},  pad_oe,  e_poe);
    endtask

    task automatic do_reset(input logic s);
        rst_n = 1'b0; strap = s;
        m_out = '0; m_dir = '0; m_gpio = s;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [N-1:0] r, pat;
        logic [7:0] seed;
        do_reset(1'b1);
        // R1 reset state
        rd(3'd1, r); check("R1 out reset", r, '0);
        rd(3'd4, r); check("R1 dir reset", r, '0);
        check("R1 oe reset", pad_oe, '0);
        rd(3'd5, r); check("R8 mode strap high", r, 8'h01);

        // mixed sweep of set/clear/toggle/direction
        seed = 8'h5A;
        for (int k = 0; k < 200; k++) begin
            seed = seed * 8'd37 + 8'd11;
            pat = seed;
            case (k % 4)
                0: begin wr(3'd1, pat); m_out = m_out | pat;  rd(3'd1, r); check("R2 set", r, m_out); end
                1: begin wr(3'd2, pat); m_out = m_out & ~pat; rd(3'd2, r); check("R3 clear", r, m_out); end
                2: begin wr(3'd3, pat); m_out = m_out ^ pat;  rd(3'd3, r); check("R4 toggle", r, m_out); end
                default: begin wr(3'd4, pat); m_dir = pat; rd(3'd4, r); check("R5 dir", r, m_dir); end
            endcase
            check_pads("R5 R7 pads");
        end

        // exhaustive set and clear of every single bit from a known base
        for (int b = 0; b < N; b++) begin
            wr(3'd2, '1); m_out = '0;
            wr(3'd1, N'(1) << b); m_out = N'(1) << b;
            rd(3'd1, r); check("R2 single set", r, m_out);
            wr(3'd1, '1); wr(3'd2, N'(1) << b); m_out = ~(N'(1) << b);
            rd(3'd1, r); check("R3 single clear", r, m_out);
            wr(3'd3, '0); rd(3'd1, r); check("R4 zero toggle", r, m_out);
        end

        // R6 input synchronizer latency and ignored data writes
        wr(3'd4, '0); m_dir = '0;
        for (int v = 0; v < 256; v += 17) begin
            logic [N-1:0] old;
            old = ext_lvl;
            @(negedge clk); ext_lvl = N'(v);
            @(negedge clk); rd(3'd0, r); check("R6 one edge stale", r, old);
            @(negedge clk); rd(3'd0, r); check("R6 two edge level", r, N'(v));
        end
        wr(3'd0, 8'hA5);
        rd(3'd1, r); check("R6 data write out", r, m_out);
        rd(3'd4, r); check("R6 data write dir", r, m_dir);

        // R10 unused addresses
        wr(3'd6, '1); wr(3'd7, 8'h3C);
        rd(3'd6, r); check("R10 addr6 read", r, '0);
        rd(3'd7, r); check("R10 addr7 read", r, '0);
        rd(3'd1, r); check("R10 out after unused", r, m_out);
        rd(3'd4, r); check("R10 dir after unused", r, m_dir);

        // R8 locked mode
        alt_out = 3'b101; alt_oe = 3'b111;
        wr(3'd5, '0);
        rd(3'd5, r); check("R8 mode locked", r, 8'h01);
        wr(3'd4, '1); m_dir = '1;
        check_pads("R8 group gpio");

        // R9 strap low
        do_reset(1'b0);
        rd(3'd5, r); check("R9 mode strap low", r, 8'h00);
        wr(3'd4, '1); m_dir = '1;
        wr(3'd1, 8'hFF); m_out = 8'hFF;
        for (int a = 0; a < 8; a++) begin
            alt_out = 3'(a); alt_oe = 3'(7 - a);
            check_pads("R9 alt pads");
        end
        wr(3'd5, 8'h01); m_gpio = 1'b1;
        rd(3'd5, r); check("R9 mode to gpio", r, 8'h01);
        check_pads("R9 gpio pads");
        wr(3'd5, 8'h00); m_gpio = 1'b0;
        rd(3'd5, r); check("R9 mode back alt", r, 8'h00);
        check_pads("R9 alt again");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule